// File: doc/BRIEF.md
# Two-Bit Serial Configuration Bus Slave

This block is the target end of a narrow serial configuration link. All of its logic runs on the interface clock. A master holds a request line high and sends a header two bits per clock. The first beat carries the transfer direction together with address bit 0, and the remaining address bits follow one pair per beat, lowest pair first. A write then carries 32 data bits in 16 two-bit beats. A read has the slave return 32 bits on its own two-bit output, and an acknowledge line marks the beats the slave drives.

Behind the bus sits a small bank of 8-bit configuration registers. Location 0x00 is a spare register that can be written and read back but controls nothing. Location 0x01 holds the control word for one synthesized output clock: a divisor, a phase-step bit and an enable. Each write that takes the phase-step bit from 0 to 1 produces a one-clock request pulse for downstream logic, and each such pulse moves the output clock by one eighth of a period.

The bus has no back-pressure. Every beat is taken on the clock it is presented, and the master paces a transfer only through the request line. When the master lets request fall before the transfer ends, the transfer is abandoned.

Top module: `sbus_cfg_slave`

## Requirements
- R1: A synchronous active-high reset sets both registers to zero, returns the bus logic to idle, and holds acknowledge, the output pair, the divisor, the enable and the phase pulse at zero.
- R2: The first beat sampled with request high is the header beat: bit 0 is the direction (0 = read, 1 = write) and bit 1 is address bit 0. The next 8 beats carry address bits {A2,A1} through {A16,A15}, lowest pair first.
- R3: A write is followed by 16 data beats, {D1,D0} first and {D31,D30} last. The addressed register takes data bits 7:0. Acknowledge is high for exactly one clock, the clock after the last data beat, and the new register value is visible in that same clock.
- R4: On a read, acknowledge is high for 16 clocks, starting the clock after the last address beat. The output pair carries the zero-extended register value as {D1,D0} first through {D31,D30} last. When acknowledge is low, the output pair is 0.
- R5: Register 0x01 drives the divisor output from bits 5:0 and the clock-enable output from bit 7.
- R6: The phase-step output pulses for exactly one clock, in the acknowledge clock of a write to 0x01, only when that write changes bit 6 from 0 to 1.
- R7: Register 0x00 reads back what was written to it, and writing it changes no output.
- R8: Only address bits 7:0 select a register. A write to an unmapped address changes nothing, and a read from one returns zero.
- R9: If request falls before a transfer completes, the slave returns to idle, acknowledge is low on the next clock, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| sbus_req_i | input | 1 | Transfer request from the master |
| sbus_din_i | input | 2 | Header and write-data beats from the master |
| sbus_ack_o | output | 1 | Acknowledge from the slave |
| sbus_dout_o | output | 2 | Read-data beats to the master |
| clk_div_o | output | 6 | Output clock divisor (register 0x01 bits 5:0) |
| clk_en_o | output | 1 | Output clock enable (register 0x01 bit 7) |
| phase_step_o | output | 1 | One-clock phase advance request |

## Verification
The bench goes after beat ordering. A slave that swapped the bits of a pair, or that put the direction flag in the wrong half of the header beat, would read back values with their pairs reversed, or would treat reads as writes. It aborts transfers at random beats to catch a design that commits a half-shifted word or leaves acknowledge high. It also writes the phase bit again while it is already set, to catch a pulse on level instead of on the edge. Finally, it uses aliased high address bits and unmapped addresses to expose decoding of the full address or writes that reach the wrong register.

// File: rtl/sbus_cfg_pkg.sv
package sbus_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_HOLD
  } bus_st_e;

  localparam int CTL_DIV_W   = 6;
  localparam int CTL_PH_BIT  = 6;
  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_REG_IDX = 1;
endpackage

// File: rtl/sbus_shift_fsm.sv
module sbus_shift_fsm
  import sbus_cfg_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 2,
  parameter int REG_W  = 8,
  parameter int SEL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [BEAT_W-1:0] din_i,
  output logic              ack_o,
  output logic [BEAT_W-1:0] dout_o,
  output logic [SEL_W-1:0]  rd_sel_o,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic              wr_en_o,
  output logic [SEL_W-1:0]  wr_sel_o,
  output logic [REG_W-1:0]  wr_data_o
);
  localparam int HDR_W      = ADDR_W + 1;
  localparam int ADDR_BEATS = (HDR_W + BEAT_W - 1) / BEAT_W;
  localparam int HDR_SH_W   = ADDR_BEATS * BEAT_W;
  localparam int DATA_BEATS = DATA_W / BEAT_W;
  localparam int MAX_BEATS  = (ADDR_BEATS > DATA_BEATS) ? ADDR_BEATS : DATA_BEATS;
  localparam int CNT_W      = $clog2(MAX_BEATS + 1);

  bus_st_e             st_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [HDR_SH_W-1:0] hdr_q, hdr_nxt;
  logic [DATA_W-1:0]   wsh_q, wsh_nxt;
  logic [DATA_W-1:0]   rsh_q;

  assign hdr_nxt = {din_i, hdr_q[HDR_SH_W-1:BEAT_W]};
  assign wsh_nxt = {din_i, wsh_q[DATA_W-1:BEAT_W]};

  // header bit 0 is the direction flag, address starts at bit 1
  assign rd_sel_o  = hdr_nxt[SEL_W:1];
  assign wr_sel_o  = hdr_q[SEL_W:1];
  assign wr_data_o = wsh_nxt[REG_W-1:0];
  assign wr_en_o   = (st_q == ST_WDATA) && req_i && (cnt_q == CNT_W'(DATA_BEATS - 1));

  assign ack_o  = (st_q == ST_WACK) || (st_q == ST_RDATA);
  assign dout_o = (st_q == ST_RDATA) ? rsh_q[BEAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      hdr_q <= '0;
      wsh_q <= '0;
      rsh_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            hdr_q <= hdr_nxt;
            cnt_q <= CNT_W'(1);
            st_q  <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (!req_i) begin
            st_q <= ST_IDLE;
          end else begin
            hdr_q <= hdr_nxt;
            if (cnt_q == CNT_W'(ADDR_BEATS - 1)) begin
              cnt_q <= '0;
              if (hdr_nxt[0]) begin
                st_q <= ST_WDATA;
              end else begin
                rsh_q <= DATA_W'(rd_data_i);
                st_q  <= ST_RDATA;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_WDATA: begin
          if (!req_i) begin
            st_q <= ST_IDLE;
          end else begin
            wsh_q <= wsh_nxt;
            if (cnt_q == CNT_W'(DATA_BEATS - 1)) st_q <= ST_WACK;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WACK: st_q <= req_i ? ST_HOLD : ST_IDLE;
        ST_RDATA: begin
          if (!req_i) begin
            st_q <= ST_IDLE;
          end else begin
            rsh_q <= rsh_q >> BEAT_W;
            if (cnt_q == CNT_W'(DATA_BEATS - 1)) st_q <= ST_HOLD;
            else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: if (!req_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbus_reg_bank.sv
module sbus_reg_bank
  import sbus_cfg_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int SEL_W    = 8,
  parameter int NUM_REGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] ctl_o,
  output logic             step_o
);
  logic [REG_W-1:0] reg_q [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) reg_q[gi] <= '0;
      else if (wr_en_i && (wr_sel_i == SEL_W'(gi))) reg_q[gi] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_sel_i == SEL_W'(i)) rd_data_o = reg_q[i];
    end
  end

  assign ctl_o = reg_q[CTL_REG_IDX];

  always_ff @(posedge clk) begin
    if (rst) step_o <= 1'b0;
    else step_o <= wr_en_i && (wr_sel_i == SEL_W'(CTL_REG_IDX))
                   && !reg_q[CTL_REG_IDX][CTL_PH_BIT] && wr_data_i[CTL_PH_BIT];
  end
endmodule

// File: rtl/sbus_cfg_slave.sv
module sbus_cfg_slave
  import sbus_cfg_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 32,
  parameter int BEAT_W   = 2,
  parameter int REG_W    = 8,
  parameter int NUM_REGS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sbus_req_i,
  input  logic [BEAT_W-1:0]    sbus_din_i,
  output logic                 sbus_ack_o,
  output logic [BEAT_W-1:0]    sbus_dout_o,
  output logic [CTL_DIV_W-1:0] clk_div_o,
  output logic                 clk_en_o,
  output logic                 phase_step_o
);
  localparam int SEL_W = 8;

  logic [SEL_W-1:0] rd_sel, wr_sel;
  logic [REG_W-1:0] rd_data, wr_data, ctl;
  logic             wr_en;

  sbus_shift_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_W(BEAT_W), .REG_W(REG_W), .SEL_W(SEL_W)
  ) fsm_i (
    .clk(clk), .rst(rst), .req_i(sbus_req_i), .din_i(sbus_din_i),
    .ack_o(sbus_ack_o), .dout_o(sbus_dout_o),
    .rd_sel_o(rd_sel), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data)
  );

  sbus_reg_bank #(
    .REG_W(REG_W), .SEL_W(SEL_W), .NUM_REGS(NUM_REGS)
  ) regs_i (
    .clk(clk), .rst(rst), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .ctl_o(ctl), .step_o(phase_step_o)
  );

  assign clk_div_o = ctl[CTL_DIV_W-1:0];
  assign clk_en_o  = ctl[CTL_EN_BIT];
endmodule

// File: rtl/sbus_cfg_slave_chk.sv
module sbus_cfg_slave_chk (
  input logic       clk,
  input logic       rst,
  input logic       sbus_req_i,
  input logic       sbus_ack_o,
  input logic [1:0] sbus_dout_o,
  input logic [5:0] clk_div_o,
  input logic       clk_en_o,
  input logic       phase_step_o
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (clk_div_o == '0 && !clk_en_o && !sbus_ack_o && !phase_step_o)); // R1

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !sbus_ack_o |-> (sbus_dout_o == '0)); // R4

  AST_CTL_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    !sbus_ack_o |-> ($stable(clk_div_o) && $stable(clk_en_o))); // R3

  AST_STEP_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    phase_step_o |-> sbus_ack_o); // R6

  AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    phase_step_o |=> !phase_step_o); // R6

  AST_ABORT_DROPS_ACK: assert property (@(posedge clk) disable iff (rst)
    !sbus_req_i |=> !sbus_ack_o); // R9
endmodule

bind sbus_cfg_slave sbus_cfg_slave_chk chk_i (
  .clk(clk), .rst(rst), .sbus_req_i(sbus_req_i), .sbus_ack_o(sbus_ack_o),
  .sbus_dout_o(sbus_dout_o), .clk_div_o(clk_div_o), .clk_en_o(clk_en_o),
  .phase_step_o(phase_step_o)
);

// File: tb/sbus_cfg_slave_tb.sv
module sbus_cfg_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [1:0] din = '0;
  logic       ack;
  logic [1:0] dout;
  logic [5:0] div;
  logic       en;
  logic       step;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_reg [2];

  always #4 clk = ~clk;

  sbus_cfg_slave dut_i (
    .clk(clk), .rst(rst), .sbus_req_i(req), .sbus_din_i(din),
    .sbus_ack_o(ack), .sbus_dout_o(dout), .clk_div_o(div),
    .clk_en_o(en), .phase_step_o(step)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [16:0] a);
    if (a[7:0] < 8'd2) return {24'b0, m_reg[a[0]]};
    return '0;
  endfunction

  task automatic beat(input logic [1:0] b);
    @(negedge clk);
    req = 1'b1;
    din = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0;
      din = '0;
    end
  endtask

  task automatic chk_ctl(input string rq);
    chk(rq, {26'b0, div}, {26'b0, m_reg[1][5:0]});
    chk(rq, {31'b0, en}, {31'b0, m_reg[1][7]});
  endtask

  // abort_at < 0: full transfer, else drop request after that many beats
  task automatic wr(input logic [16:0] a, input logic [31:0] d, input int abort_at);
    logic [17:0] h;
    logic        exp_step;
    h = {a, 1'b1};
    for (int i = 0; i < 25; i++) begin
      if (i == abort_at) begin
        idle(1);
        @(negedge clk);
        chk("R9 ack low after abort", {31'b0, ack}, 32'd0);
        chk_ctl("R9 no change after abort");
        return;
      end
      beat(i < 9 ? h[2*i +: 2] : d[2*(i-9) +: 2]);
    end
    exp_step = (a[7:0] == 8'd1) && !m_reg[1][6] && d[6];
    if (a[7:0] < 8'd2) m_reg[a[0]] = d[7:0];
    @(negedge clk);
    chk("R3 write ack", {31'b0, ack}, 32'd1);
    chk_ctl("R5 ctl fields at ack");
    chk("R6 phase pulse", {31'b0, step}, {31'b0, exp_step});
    @(negedge clk);
    chk("R3 ack single cycle", {31'b0, ack}, 32'd0);
    chk("R6 pulse single cycle", {31'b0, step}, 32'd0);
    idle(1);
  endtask

  task automatic rd(input logic [16:0] a, input int abort_at, output logic [31:0] got);
    logic [17:0] h;
    h   = {a, 1'b0};
    got = '0;
    for (int i = 0; i < 9; i++) beat(h[2*i +: 2]);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (i == abort_at) begin
        req = 1'b0;
        @(negedge clk);
        chk("R9 read abort ack low", {31'b0, ack}, 32'd0);
        idle(1);
        return;
      end
      chk("R4 read ack high", {31'b0, ack}, 32'd1);
      got[2*i +: 2] = dout;
    end
    @(negedge clk);
    chk("R4 ack low after 16 beats", {31'b0, ack}, 32'd0);
    chk("R4 dout idle", {30'b0, dout}, 32'd0);
    idle(1);
  endtask

  task automatic rd_chk(input logic [16:0] a, input string rq);
    logic [31:0] g;
    rd(a, -1, g);
    chk(rq, g, exp_read(a));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] g;
    void'($urandom(32'd4242));
    m_reg[0] = '0;
    m_reg[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ack", {31'b0, ack}, 32'd0);
    chk("R1 reset dout", {30'b0, dout}, 32'd0);
    chk("R1 reset step", {31'b0, step}, 32'd0);
    chk_ctl("R1 reset ctl");
    rd_chk(17'h00001, "R1 reset reg1 reads zero");

    // directed: distinct pair patterns to catch pair/bit swaps (R2)
    wr(17'h00001, 32'h0000_00B4, -1);
    rd_chk(17'h00001, "R2 R4 readback pattern B4");
    wr(17'h00001, 32'hFFFF_FF2D, -1);
    rd_chk(17'h00001, "R2 R3 upper data ignored");

    // R7: reserved register holds value, outputs untouched
    wr(17'h00000, 32'h0000_00C3, -1);
    chk_ctl("R7 reg0 write leaves outputs");
    rd_chk(17'h00000, "R7 reg0 readback");

    // R6: phase bit already set, write again with bit 6 set -> no pulse
    wr(17'h00001, 32'h0000_0041, -1);
    wr(17'h00001, 32'h0000_0042, -1);
    wr(17'h00001, 32'h0000_0000, -1);
    wr(17'h00001, 32'h0000_00C0, -1);

    // R8: high address bits alias, unmapped ignored / reads zero
    wr(17'h1FF01, 32'h0000_0015, -1);
    rd_chk(17'h00001, "R8 alias write hit reg1");
    wr(17'h00002, 32'h0000_00FF, -1);
    chk_ctl("R8 unmapped write ignored");
    rd_chk(17'h00002, "R8 unmapped read zero");
    rd_chk(17'h000FF, "R8 unmapped read zero FF");
    rd_chk(17'h10000, "R8 alias read reg0");

    // R9: aborts at header, data and read phases
    wr(17'h00001, 32'h0000_00EE, 5);
    wr(17'h00001, 32'h0000_00EE, 24);
    rd(17'h00001, 7, g);
    rd_chk(17'h00001, "R9 reg1 unchanged after aborts");

    // random mix
    for (int n = 0; n < 150; n++) begin
      logic [16:0] a;
      logic [31:0] d;
      int          k;
      a = 17'($urandom);
      if ($urandom % 4 != 0) a[7:0] = 8'($urandom % 3);
      d = $urandom;
      k = $urandom % 10;
      if (k < 5) wr(a, d, -1);
      else if (k < 6) wr(a, d, 1 + int'($urandom % 24));
      else if (k < 7) rd(a, int'($urandom % 16), g);
      else rd_chk(a, "R4 R8 random read");
    end
    rd_chk(17'h00000, "R7 final reg0");
    rd_chk(17'h00001, "R3 final reg1");

    // R1: reset mid-transfer clears everything
    beat(2'b11);
    beat(2'b10);
    rst = 1'b1;
    m_reg[0] = '0;
    m_reg[1] = '0;
    idle(2);
    rst = 1'b0;
    @(negedge clk);
    chk_ctl("R1 reset clears ctl");
    rd_chk(17'h00000, "R1 reset clears reg0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule